// File: doc/BRIEF.md
# Binary Calendar Clock with Alarm

This block keeps wall-clock time in plain binary fields: second, minute, hour, weekday, day of month, month and a 12-bit year. A reference clock feeds a programmable divider; every time the divider wraps, the calendar moves forward by one second. Carries propagate through the fields. Month lengths follow the calendar, and a leap year can be switched off by a control bit.

Software sets the time in two steps. It first writes the wanted date and time into two staging registers. It then commits them with a load strobe in the control register. The load also restarts the divider phase, so the new time lasts a full second. An enable bit starts and stops counting. A read-only running flag follows the enable bit one cycle later and shows whether the counters really advance.

An alarm comparator checks the live time against a programmed target. Each of the seven fields has its own match enable, and a master enable gates the whole comparator. A hit sets a level-sensitive raw interrupt. That raw bit is ORed with a software force bit and ANDed with a mask bit. The result drives a registered interrupt pin and a masked-status register.

Top module: `cal_rtc`

## Requirements
- R1: After reset every counter, staging, alarm, divider and control register reads zero, and `irq` is low.
- R2: The divider register (word 0, bits [15:0]) holds N. While running, the second advances once every N+1 clocks.
- R3: Writing 1 to control bit 1 (word 3) copies the staged date and time into the counters, and that bit reads back as 0. The staged date (word 1) has year in [11:0], month in [15:12] and day in [20:16]. The staged time (word 2) has second in [5:0], minute in [11:6], hour in [16:12] and weekday in [22:20]. The load restarts the divider, so the first advance after it comes N+1 clocks later.
- R4: Control bit 0 enables counting. Control bit 3 is read-only and shows the running state, which copies the enable bit one clock later. Counters advance only while running.
- R5: Second 59 wraps to 0 and carries into the minute. Minute 59 wraps to 0 and carries into the hour. Hour 23 wraps to 0 and carries into the day.
- R6: On a day carry, the weekday goes 7 to 1 (1 = Monday). The day of month wraps to 1 after the last day of the month: 30 days for months 4, 6, 9 and 11, 31 for the other months. Month 12 wraps to 1 and increments the year.
- R7: February has 29 days when the year is divisible by 4 and control bit 2 is clear. Otherwise it has 28 days.
- R8: The alarm target date (word 4) and target time (word 5) use the same field layout as the staging registers. The per-field enables are year, month and day at word 4 bits 24, 25 and 26, and second, minute, hour and weekday at word 5 bits 24, 25, 26 and 27. The master enable is word 4 bit 28, and word 4 bit 29 reads back the master enable. The alarm matches when the master enable is set and every enabled field equals its target.
- R9: Raw interrupt (word 8, bit 0) is the match condition registered one clock later. It is level-sensitive and clears once the time no longer matches.
- R10: Interrupt enable is word 9 bit 0 and interrupt force is word 10 bit 0. Masked status (word 11, bit 0) and the `irq` pin both equal (raw OR force) AND enable, registered.
- R11: Word 6 returns the live date and word 7 the live time, in the staging layouts. Read data is registered and appears one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Masked interrupt |

## Verification
The bench pushes the calendar across every carry boundary: second, minute and hour wraps, weekday 7, 30- and 31-day months, February in leap and common years, the leap override, and the year end. A design with a wrong month table or leap test would show the wrong date one second later. The bench measures the divider period, and the phase after a load started mid-second. An off-by-one divider would show a period of N or N+2. A load that keeps the old phase would advance the new time too early. The alarm tests enable fields one by one, with matching and mismatching targets, and toggle the master enable, force and mask bits. A comparator that ignores a field enable, or a mask applied before the force, would show at `irq`.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int YEAR_W  = 12;
  localparam int MONTH_W = 4;
  localparam int DAY_W   = 5;
  localparam int DOW_W   = 3;
  localparam int HOUR_W  = 5;
  localparam int MIN_W   = 6;
  localparam int SEC_W   = 6;
  localparam int NFIELDS = 7;

  // field enable index
  localparam int F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_DOW = 3, F_DAY = 4, F_MONTH = 5, F_YEAR = 6;

  // register word addresses
  localparam logic [3:0] A_DIV = 4'd0, A_SDATE = 4'd1, A_STIME = 4'd2, A_CTRL = 4'd3,
                         A_ADATE = 4'd4, A_ATIME = 4'd5, A_NDATE = 4'd6, A_NTIME = 4'd7,
                         A_RAW = 4'd8, A_IEN = 4'd9, A_IFRC = 4'd10, A_ISTAT = 4'd11;

  typedef struct packed {
    logic [YEAR_W-1:0]  year;
    logic [MONTH_W-1:0] month;
    logic [DAY_W-1:0]   day;
    logic [DOW_W-1:0]   dow;
    logic [HOUR_W-1:0]  hour;
    logic [MIN_W-1:0]   min;
    logic [SEC_W-1:0]   sec;
  } rtc_time_t;

  function automatic logic [DAY_W-1:0] month_len(input logic [MONTH_W-1:0] m,
                                                 input logic [YEAR_W-1:0] y,
                                                 input logic no_leap);
    case (m)
      4'd2:                      return (y[1:0] == 2'b00 && !no_leap) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  function automatic logic [31:0] date_word(input rtc_time_t t);
    logic [31:0] w;
    w = '0;
    w[11:0]  = t.year;
    w[15:12] = t.month;
    w[20:16] = t.day;
    return w;
  endfunction

  function automatic logic [31:0] time_word(input rtc_time_t t);
    logic [31:0] w;
    w = '0;
    w[5:0]   = t.sec;
    w[11:6]  = t.min;
    w[16:12] = t.hour;
    w[22:20] = t.dow;
    return w;
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && !restart && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt_q <= '0;
    else if (cnt_q == div)      cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  input  logic      no_leap,
  output rtc_time_t now
);
  rtc_time_t nx;
  logic [DAY_W-1:0] mlen;

  always_comb begin
    mlen = month_len(now.month, now.year, no_leap);
    nx = now;
    if (now.sec >= 6'd59) begin
      nx.sec = '0;
      if (now.min >= 6'd59) begin
        nx.min = '0;
        if (now.hour >= 5'd23) begin
          nx.hour = '0;
          nx.dow  = (now.dow >= 3'd7) ? 3'd1 : now.dow + 3'd1;
          if (now.day >= mlen) begin
            nx.day = 5'd1;
            if (now.month >= 4'd12) begin
              nx.month = 4'd1;
              nx.year  = now.year + 1'b1;
            end else begin
              nx.month = now.month + 1'b1;
            end
          end else begin
            nx.day = now.day + 1'b1;
          end
        end else begin
          nx.hour = now.hour + 1'b1;
        end
      end else begin
        nx.min = now.min + 1'b1;
      end
    end else begin
      nx.sec = now.sec + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       now <= '0;
    else if (load) now <= load_val;
    else if (tick) now <= nx;
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  rtc_time_t          now,
  input  rtc_time_t          target,
  input  logic [NFIELDS-1:0] field_en,
  input  logic               global_en,
  output logic               match,
  output logic               raw
);
  logic [NFIELDS-1:0] eq;

  assign eq[F_SEC]   = now.sec   == target.sec;
  assign eq[F_MIN]   = now.min   == target.min;
  assign eq[F_HOUR]  = now.hour  == target.hour;
  assign eq[F_DOW]   = now.dow   == target.dow;
  assign eq[F_DAY]   = now.day   == target.day;
  assign eq[F_MONTH] = now.month == target.month;
  assign eq[F_YEAR]  = now.year  == target.year;

  assign match = global_en && (&(eq | ~field_en));

  always_ff @(posedge clk) begin
    if (rst) raw <= 1'b0;
    else     raw <= match;
  end
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import rtc_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [DIV_W-1:0]   div_q;
  rtc_time_t          stage_q, alm_q, now;
  logic [NFIELDS-1:0] alm_en_q;
  logic               glob_q, enable_q, active_q, no_leap_q;
  logic               irq_en_q, irq_force_q, irq_q, raw, match, tick, load, div_wr;
  logic [DATA_W-1:0]  rd_mux;

  assign load   = reg_we && (reg_addr == ADDR_W'(A_CTRL)) && reg_wdata[1];
  assign div_wr = reg_we && (reg_addr == ADDR_W'(A_DIV));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0; stage_q <= '0; alm_q <= '0; alm_en_q <= '0;
      glob_q <= 1'b0; enable_q <= 1'b0; active_q <= 1'b0; no_leap_q <= 1'b0;
      irq_en_q <= 1'b0; irq_force_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      active_q <= enable_q;
      irq_q    <= (raw | irq_force_q) & irq_en_q;
      if (reg_we) begin
        case (reg_addr)
          ADDR_W'(A_DIV):   div_q <= reg_wdata[DIV_W-1:0];
          ADDR_W'(A_SDATE): begin
            stage_q.year  <= reg_wdata[11:0];
            stage_q.month <= reg_wdata[15:12];
            stage_q.day   <= reg_wdata[20:16];
          end
          ADDR_W'(A_STIME): begin
            stage_q.sec  <= reg_wdata[5:0];
            stage_q.min  <= reg_wdata[11:6];
            stage_q.hour <= reg_wdata[16:12];
            stage_q.dow  <= reg_wdata[22:20];
          end
          ADDR_W'(A_CTRL): begin
            enable_q  <= reg_wdata[0];
            no_leap_q <= reg_wdata[2];
          end
          ADDR_W'(A_ADATE): begin
            alm_q.year  <= reg_wdata[11:0];
            alm_q.month <= reg_wdata[15:12];
            alm_q.day   <= reg_wdata[20:16];
            alm_en_q[F_YEAR]  <= reg_wdata[24];
            alm_en_q[F_MONTH] <= reg_wdata[25];
            alm_en_q[F_DAY]   <= reg_wdata[26];
            glob_q <= reg_wdata[28];
          end
          ADDR_W'(A_ATIME): begin
            alm_q.sec  <= reg_wdata[5:0];
            alm_q.min  <= reg_wdata[11:6];
            alm_q.hour <= reg_wdata[16:12];
            alm_q.dow  <= reg_wdata[22:20];
            alm_en_q[F_SEC]  <= reg_wdata[24];
            alm_en_q[F_MIN]  <= reg_wdata[25];
            alm_en_q[F_HOUR] <= reg_wdata[26];
            alm_en_q[F_DOW]  <= reg_wdata[27];
          end
          ADDR_W'(A_IEN):  irq_en_q    <= reg_wdata[0];
          ADDR_W'(A_IFRC): irq_force_q <= reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  rtc_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(active_q), .restart(load), .div(div_q), .tick(tick)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .load_val(stage_q),
    .no_leap(no_leap_q), .now(now)
  );

  rtc_alarm u_alm (
    .clk(clk), .rst(rst), .now(now), .target(alm_q), .field_en(alm_en_q),
    .global_en(glob_q), .match(match), .raw(raw)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(A_DIV):   rd_mux[DIV_W-1:0] = div_q;
      ADDR_W'(A_SDATE): rd_mux = date_word(stage_q);
      ADDR_W'(A_STIME): rd_mux = time_word(stage_q);
      ADDR_W'(A_CTRL):  begin
        rd_mux[0] = enable_q; rd_mux[2] = no_leap_q; rd_mux[3] = active_q;
      end
      ADDR_W'(A_ADATE): begin
        rd_mux = date_word(alm_q);
        rd_mux[24] = alm_en_q[F_YEAR]; rd_mux[25] = alm_en_q[F_MONTH];
        rd_mux[26] = alm_en_q[F_DAY];  rd_mux[28] = glob_q; rd_mux[29] = glob_q;
      end
      ADDR_W'(A_ATIME): begin
        rd_mux = time_word(alm_q);
        rd_mux[24] = alm_en_q[F_SEC];  rd_mux[25] = alm_en_q[F_MIN];
        rd_mux[26] = alm_en_q[F_HOUR]; rd_mux[27] = alm_en_q[F_DOW];
      end
      ADDR_W'(A_NDATE): rd_mux = date_word(now);
      ADDR_W'(A_NTIME): rd_mux = time_word(now);
      ADDR_W'(A_RAW):   rd_mux[0] = raw;
      ADDR_W'(A_IEN):   rd_mux[0] = irq_en_q;
      ADDR_W'(A_IFRC):  rd_mux[0] = irq_force_q;
      ADDR_W'(A_ISTAT): rd_mux[0] = irq_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign irq = irq_q;
endmodule

// File: rtl/cal_rtc_checker.sv
module cal_rtc_checker
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      tick,
  input logic      load,
  input logic      div_wr,
  input logic [15:0] div_q,
  input logic      enable_q,
  input logic      active_q,
  input rtc_time_t now,
  input rtc_time_t stage_q,
  input logic      glob_q,
  input logic      raw,
  input logic      irq_force_q,
  input logic      irq_en_q,
  input logic      irq
);
  // R4: running flag copies enable one clock later
  a_r4_active_lag: assert property (@(posedge clk) disable iff (rst)
    enable_q |=> active_q);
  a_r4_active_drop: assert property (@(posedge clk) disable iff (rst)
    !enable_q |=> !active_q);

  // R2: with N > 0 ticks are never back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && div_q != 16'd0 && !div_wr) |=> !tick);

  // R5: time holds when no tick and no load
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> now == $past(now));

  // R3: load copies staged values
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    load |=> now == $past(stage_q));

  // R8: no match without master enable
  a_r8_global_gate: assert property (@(posedge clk) disable iff (rst)
    !glob_q |=> !raw);

  // R10: masking and forcing at the pin
  a_r10_forced: assert property (@(posedge clk) disable iff (rst)
    (irq_force_q && irq_en_q) |=> irq);
  a_r10_masked: assert property (@(posedge clk) disable iff (rst)
    !irq_en_q |=> !irq);
endmodule

bind cal_rtc cal_rtc_checker u_chk (
  .clk(clk), .rst(rst), .tick(tick), .load(load), .div_wr(div_wr), .div_q(div_q),
  .enable_q(enable_q), .active_q(active_q), .now(now), .stage_q(stage_q),
  .glob_q(glob_q), .raw(raw), .irq_force_q(irq_force_q), .irq_en_q(irq_en_q), .irq(irq)
);

// File: tb/test_cal_rtc.sv
module test_cal_rtc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cal_rtc i_cal_rtc (.clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
                     .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  // inputs: year, month, day, dow, hour, min, sec, no_leap
  localparam int NV = 11;
  localparam int VI [0:10][0:7] = '{
    '{2024, 3, 15, 5, 10, 20, 30, 0},
    '{2024, 3, 15, 5, 10, 20, 59, 0},
    '{2024, 3, 15, 5, 10, 59, 59, 0},
    '{2024, 3, 15, 7, 23, 59, 59, 0},
    '{2024, 2, 28, 3, 23, 59, 59, 0},
    '{2024, 2, 28, 3, 23, 59, 59, 1},
    '{2023, 2, 28, 2, 23, 59, 59, 0},
    '{2024, 2, 29, 4, 23, 59, 59, 0},
    '{2024, 4, 30, 2, 23, 59, 59, 0},
    '{2024, 1, 31, 3, 23, 59, 59, 0},
    '{2024, 12, 31, 2, 23, 59, 59, 0}
  };
  // expected after one second: year, month, day, dow, hour, min, sec
  localparam int VO [0:10][0:6] = '{
    '{2024, 3, 15, 5, 10, 20, 31},
    '{2024, 3, 15, 5, 10, 21, 0},
    '{2024, 3, 15, 5, 11, 0, 0},
    '{2024, 3, 16, 1, 0, 0, 0},
    '{2024, 2, 29, 4, 0, 0, 0},
    '{2024, 3, 1, 4, 0, 0, 0},
    '{2023, 3, 1, 3, 0, 0, 0},
    '{2024, 3, 1, 5, 0, 0, 0},
    '{2024, 5, 1, 3, 0, 0, 0},
    '{2024, 2, 1, 4, 0, 0, 0},
    '{2025, 1, 1, 3, 0, 0, 0}
  };

  function automatic logic [31:0] mk_date(int y, int m, int d);
    return (32'(d) << 16) | (32'(m) << 12) | 32'(y);
  endfunction
  function automatic logic [31:0] mk_time(int h, int mi, int s, int w);
    return (32'(w) << 20) | (32'(h) << 12) | (32'(mi) << 6) | 32'(s);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, t, prev;
    int c1, c2, n;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(4'd3, d);  check("R1 ctrl", d, 32'h0);
    rd(4'd6, d);  check("R1 date", d, 32'h0);
    rd(4'd7, d);  check("R1 time", d, 32'h0);
    rd(4'd0, d);  check("R1 div", d, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);

    // R6 R5 R7 R11 vector walk, N=9
    wr(4'd0, 32'd9);
    for (int i = 0; i < NV; i++) begin
      wr(4'd1, mk_date(VI[i][0], VI[i][1], VI[i][2]));
      wr(4'd2, mk_time(VI[i][4], VI[i][5], VI[i][6], VI[i][3]));
      wr(4'd3, 32'h2 | (32'(VI[i][7]) << 2));
      wr(4'd3, 32'h1 | (32'(VI[i][7]) << 2));
      idle(13);
      wr(4'd3, 32'(VI[i][7]) << 2);
      rd(4'd6, d);
      rd(4'd7, t);
      check($sformatf("R5/R6/R7 vec%0d date", i), d, mk_date(VO[i][0], VO[i][1], VO[i][2]));
      check($sformatf("R5/R6/R7 vec%0d time", i), t, mk_time(VO[i][4], VO[i][5], VO[i][6], VO[i][3]));
    end

    // R4 running flag lags enable; R3 load bit reads zero
    @(negedge clk); reg_addr = 4'd3; reg_we = 1'b1; reg_wdata = 32'h1;
    @(negedge clk); reg_we = 1'b0;
    @(negedge clk); check("R4 lag first", reg_rdata, 32'h1);
    @(negedge clk); check("R4 running", reg_rdata, 32'h9);
    wr(4'd3, 32'h0);
    idle(2);
    rd(4'd3, d); check("R4 stopped", d, 32'h0);
    // R4 no counting when stopped
    rd(4'd7, prev); idle(30); rd(4'd7, d);
    check("R4 frozen", d, prev);

    // R2 divider period N+1 with N=3
    wr(4'd0, 32'd3);
    wr(4'd3, 32'h1);
    @(negedge clk); reg_addr = 4'd7;
    @(negedge clk); prev = reg_rdata;
    c1 = -1; c2 = -1;
    for (int k = 1; k < 40 && c2 < 0; k++) begin
      @(negedge clk);
      if (reg_rdata != prev) begin
        if (c1 < 0) c1 = k; else c2 = k;
        prev = reg_rdata;
      end
    end
    check("R2 period", 32'(c2 - c1), 32'd4);

    // R3 load restarts phase, N=9, running
    wr(4'd0, 32'd9);
    idle(5);
    wr(4'd2, mk_time(1, 2, 5, 1));
    @(negedge clk); reg_addr = 4'd3; reg_we = 1'b1; reg_wdata = 32'h3;
    @(negedge clk); reg_we = 1'b0; reg_addr = 4'd7;
    n = 0;
    for (int k = 1; k < 40 && n == 0; k++) begin
      @(negedge clk);
      if (reg_rdata[5:0] != 6'd5 && k > 1) n = k;
    end
    check("R3 first tick after load", 32'(n), 32'd11);
    wr(4'd3, 32'h0);
    rd(4'd3, d); check("R3 load bit reads 0", d, 32'h0);

    // R8 R9 R10 alarm, clock stopped at 2024-03-15 dow5 10:20:32
    wr(4'd1, mk_date(2024, 3, 15));
    wr(4'd2, mk_time(10, 20, 32, 5));
    wr(4'd3, 32'h2);
    wr(4'd9, 32'h1);
    wr(4'd5, mk_time(0, 0, 32, 0) | (32'h1 << 24));
    wr(4'd4, 32'h1 << 28);
    idle(3);
    rd(4'd8, d);  check("R8 sec match raw", d, 32'h1);
    check("R10 irq on", {31'd0, irq}, 32'h1);
    rd(4'd11, d); check("R10 status", d, 32'h1);
    wr(4'd5, mk_time(0, 21, 32, 0) | (32'h3 << 24));
    idle(3); rd(4'd8, d); check("R8 minute mismatch", d, 32'h0);
    wr(4'd5, mk_time(10, 20, 32, 5) | (32'hF << 24));
    idle(3); rd(4'd8, d); check("R8 all time fields", d, 32'h1);
    wr(4'd5, mk_time(10, 20, 32, 4) | (32'hF << 24));
    idle(3); rd(4'd8, d); check("R8 weekday mismatch", d, 32'h0);
    wr(4'd5, mk_time(10, 20, 32, 4) | (32'h7 << 24));
    idle(3); rd(4'd8, d); check("R8 weekday disabled", d, 32'h1);
    wr(4'd4, mk_date(2023, 3, 15) | (32'h1 << 28) | (32'h1 << 24));
    idle(3); rd(4'd8, d); check("R8 year mismatch", d, 32'h0);
    wr(4'd4, mk_date(2024, 3, 15) | (32'h1 << 28) | (32'h7 << 24));
    idle(3); rd(4'd8, d); check("R8 date match", d, 32'h1);
    rd(4'd4, d); check("R8 readback active", d[29:28], 2'b11);
    wr(4'd4, mk_date(2024, 3, 15) | (32'h7 << 24));
    idle(3); rd(4'd8, d); check("R8 master off", d, 32'h0);
    rd(4'd4, d); check("R8 active clear", {30'd0, d[29:28]}, 32'h0);
    check("R10 irq follows raw", {31'd0, irq}, 32'h0);
    // R10 force and mask
    wr(4'd10, 32'h1);
    idle(3); check("R10 forced", {31'd0, irq}, 32'h1);
    wr(4'd9, 32'h0);
    idle(3); check("R10 force masked", {31'd0, irq}, 32'h0);
    rd(4'd11, d); check("R10 status masked", d, 32'h0);
    wr(4'd10, 32'h0);
    wr(4'd4, mk_date(2024, 3, 15) | (32'h1 << 28) | (32'h7 << 24));
    idle(3); rd(4'd8, d); check("R9 raw while masked", d, 32'h1);
    check("R10 raw masked", {31'd0, irq}, 32'h0);
    // R9 level clears after time moves on
    wr(4'd9, 32'h1);
    wr(4'd0, 32'd1);
    wr(4'd3, 32'h1);
    idle(20);
    wr(4'd3, 32'h0);
    idle(3);
    rd(4'd8, d); check("R9 raw cleared", d, 32'h0);
    check("R9 irq cleared", {31'd0, irq}, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule